// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block is the host side of a read-only serial link to two analog-to-digital converters that sit behind one shared chip select and one shared serial clock. Each converter answers on its own data-in line, and the host drives no data out. A single-cycle start request opens a frame. The block lowers chip select, runs the serial clock from a divider on the system clock, and shifts in one 16-bit word from each converter at the same time.

At the end of the frame the block raises chip select again. It then presents the low 12 bits of each word together, marked by a one-cycle valid strobe. Each channel also gets a format flag that reports whether any of the four header bits was nonzero. The serial clock idles high. The converters change data after falling edges and the block samples on rising edges, taking the most significant bit first. Each data-in line passes through a two-flop synchroniser before it is sampled.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, chip select and serial clock are high, and busy and valid are low.
- R2: A start request in idle lowers chip select and raises busy on the next clock edge. The first falling serial-clock edge comes no earlier than HALF_DIV system cycles after chip select falls.
- R3: Every frame contains exactly 16 rising serial-clock edges, and chip select rises only after the 16th one.
- R4: The serial clock is high whenever chip select is high.
- R5: Each result is bits 11..0 of the 16-bit word received on its line. Bits arrive most significant first and are sampled at rising serial-clock edges.
- R6: A channel's error flag is 1 exactly when any of bits 15..12 of its word is 1.
- R7: Both results and both error flags update together in the cycle valid is high. Valid lasts one cycle, and results hold their values until the next valid.
- R8: Busy stays high from the edge after a start until the cycle valid rises, when it drops. A start while busy is ignored, so no extra frame and no extra valid follow.
- R9: Inside a frame, each high and each low phase of the serial clock lasts exactly HALF_DIV system cycles (2.5 MHz from 125 MHz when HALF_DIV is 25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| spi_csn_o | output | 1 | Shared chip select, active low |
| spi_sclk_o | output | 1 | Shared serial clock, idles high |
| spi_miso_a_i | input | 1 | Serial data from converter A |
| spi_miso_b_i | input | 1 | Serial data from converter B |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe for new results |
| res_a_o | output | RES_W | Channel A result |
| res_b_o | output | RES_W | Channel B result |
| err_a_o | output | 1 | Channel A header bits not all zero |
| err_b_o | output | 1 | Channel B header bits not all zero |

## Verification
The assertions check the bus timing on every cycle. This covers the idle-high clock, the lead time before the first falling edge, the exact half-period length, the count of 16 rising edges before chip select rises, the single-cycle valid, the busy/chip-select relationship, and results holding steady between strobes. The value-level behaviour can only be shown by the bench scenarios, which use a converter model driving known words. These are the most-significant-first assembly of the 12-bit results, the header-bit error flags on each channel separately, and a second start issued mid-frame producing no extra frame.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH
    } dadc_state_e;

    localparam int unsigned NCH = 2;
endpackage

// File: rtl/dadc_sync.sv
module dadc_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q <= '0;
            else         stage_q <= {stage_q[0], d_i[g]};
        end
        assign q_o[g] = stage_q[1];
    end
endmodule

// File: rtl/dadc_clkgen.sv
module dadc_clkgen #(
    parameter int unsigned HALF_DIV = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dadc_shifter.sv
module dadc_shifter #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned HDR_W  = 4,
    localparam int unsigned RES_W = WORD_W - HDR_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [RES_W-1:0] res_o,
    output logic             hdr_err_o
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) word_d = {word_q[WORD_W-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
    end

    assign res_o     = word_q[RES_W-1:0];
    assign hdr_err_o = |word_q[WORD_W-1:RES_W];
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import dadc_pkg::*;
#(
    parameter int unsigned HALF_DIV = 25,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned HDR_W    = 4,
    parameter int unsigned RES_W    = WORD_W - HDR_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             spi_csn_o,
    output logic             spi_sclk_o,
    input  logic             spi_miso_a_i,
    input  logic             spi_miso_b_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES_W-1:0] res_a_o,
    output logic [RES_W-1:0] res_b_o,
    output logic             err_a_o,
    output logic             err_b_o
);
    localparam int unsigned BIT_CW = $clog2(WORD_W + 1);

    typedef struct packed {
        dadc_state_e                  state;
        logic [BIT_CW-1:0]            bits;
        logic                         sclk;
        logic                         csn;
        logic                         busy;
        logic                         valid;
        logic [NCH-1:0][RES_W-1:0]    res;
        logic [NCH-1:0]               err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state: ST_IDLE, bits: '0, sclk: 1'b1, csn: 1'b1,
        busy: 1'b0, valid: 1'b0, res: '0, err: '0
    };

    regs_t d, q;
    logic                      tick;
    logic                      shift_en;
    logic [NCH-1:0]            miso_sync;
    logic [NCH-1:0][RES_W-1:0] sh_res;
    logic [NCH-1:0]            sh_err;

    dadc_sync #(.N(NCH)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({spi_miso_b_i, spi_miso_a_i}),
        .q_o    (miso_sync)
    );

    dadc_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (q.state != ST_IDLE),
        .tick_o (tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dadc_shifter #(.WORD_W(WORD_W), .HDR_W(HDR_W)) i_shift (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .shift_i   (shift_en),
            .din_i     (miso_sync[ch]),
            .res_o     (sh_res[ch]),
            .hdr_err_o (sh_err[ch])
        );
    end

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        shift_en = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_LEAD;
                    d.csn   = 1'b0;
                    d.busy  = 1'b1;
                    d.bits  = '0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.sclk  = 1'b0;
                    d.state = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.sclk   = 1'b1;
                    shift_en = 1'b1;
                    d.bits   = q.bits + BIT_CW'(1);
                    d.state  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.bits == BIT_CW'(WORD_W)) begin
                        d.state = ST_IDLE;
                        d.csn   = 1'b1;
                        d.busy  = 1'b0;
                        d.valid = 1'b1;
                        d.res   = sh_res;
                        d.err   = sh_err;
                    end else begin
                        d.sclk  = 1'b0;
                        d.state = ST_LOW;
                    end
                end
            end
            default: d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= REGS_RST;
        else         q <= d;
    end

    assign spi_csn_o  = q.csn;
    assign spi_sclk_o = q.sclk;
    assign busy_o     = q.busy;
    assign valid_o    = q.valid;
    assign res_a_o    = q.res[0];
    assign res_b_o    = q.res[1];
    assign err_a_o    = q.err[0];
    assign err_b_o    = q.err[1];
endmodule

// File: rtl/dadc_checker.sv
module dadc_checker #(
    parameter int unsigned HALF_DIV = 25,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned RES_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csn,
    input logic             sclk,
    input logic             busy,
    input logic             valid,
    input logic [RES_W-1:0] res_a,
    input logic [RES_W-1:0] res_b
);
    logic        sclk_prev;
    logic        seen_fall;
    logic [31:0] run_len;
    logic [31:0] lead_len;
    logic [31:0] rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b1;
            seen_fall <= 1'b0;
            run_len   <= '0;
            lead_len  <= '0;
            rises     <= '0;
        end else begin
            sclk_prev <= sclk;
            run_len   <= (sclk != sclk_prev) ? 32'd1 : run_len + 32'd1;
            if (csn) begin
                seen_fall <= 1'b0;
                lead_len  <= '0;
                rises     <= '0;
            end else begin
                if (sclk_prev && !sclk) seen_fall <= 1'b1;
                if (sclk && !seen_fall) lead_len <= lead_len + 32'd1;
                if (sclk && !sclk_prev) rises <= rises + 32'd1;
            end
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        csn |-> sclk); // R4
    AST_LEAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn && $fell(sclk) && !seen_fall) |-> (lead_len >= HALF_DIV)); // R2
    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn && seen_fall && (sclk != sclk_prev)) |-> (run_len == HALF_DIV)); // R9
    AST_SIXTEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn) |-> (rises == WORD_W)); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R7
    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(res_a) && $stable(res_b))); // R7
    AST_VALID_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (csn && !busy && $past(busy))); // R8
    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !csn |-> busy); // R8
endmodule

bind dual_adc_reader dadc_checker #(
    .HALF_DIV (HALF_DIV),
    .WORD_W   (WORD_W),
    .RES_W    (RES_W)
) i_dadc_checker (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .csn   (spi_csn_o),
    .sclk  (spi_sclk_o),
    .busy  (busy_o),
    .valid (valid_o),
    .res_a (res_a_o),
    .res_b (res_b_o)
);

// File: tb/test_dual_adc_reader.sv
`timescale 1ns/1ps
module test_dual_adc_reader;
    localparam int unsigned H   = 4;
    localparam int unsigned CLK_NS = 8;
    localparam int unsigned NVEC = 8;

    // {word_a, word_b, exp_res_a, exp_res_b, exp_err_a, exp_err_b}
    localparam logic [57:0] VEC [NVEC] = '{
        {16'h0ABC, 16'h0123, 12'hABC, 12'h123, 1'b0, 1'b0},
        {16'h0FFF, 16'h0000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        {16'h0000, 16'h0FFF, 12'h000, 12'hFFF, 1'b0, 1'b0},
        {16'h8ABC, 16'h0555, 12'hABC, 12'h555, 1'b1, 1'b0},
        {16'h0AAA, 16'h1555, 12'hAAA, 12'h555, 1'b0, 1'b1},
        {16'hF000, 16'h7FFF, 12'h000, 12'hFFF, 1'b1, 1'b1},
        {16'h0800, 16'h0001, 12'h800, 12'h001, 1'b0, 1'b0},
        {16'h4555, 16'h2AAA, 12'h555, 12'hAAA, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        csn, sclk, miso_a, miso_b, busy, valid, err_a, err_b;
    logic [11:0] res_a, res_b;
    logic [15:0] mdl_a = '0, mdl_b = '0;

    int total = 0;
    int bad = 0;
    int valid_n = 0;
    int rise_n = 0;
    bit fall_seen = 0;
    time t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, lead_ns = 0, period_ns = 0;

    always #(CLK_NS/2) clk = ~clk;

    dual_adc_reader #(.HALF_DIV(H)) i_dual_adc_reader (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .spi_csn_o    (csn),
        .spi_sclk_o   (sclk),
        .spi_miso_a_i (miso_a),
        .spi_miso_b_i (miso_b),
        .busy_o       (busy),
        .valid_o      (valid),
        .res_a_o      (res_a),
        .res_b_o      (res_b),
        .err_a_o      (err_a),
        .err_b_o      (err_b)
    );

    // converter model: new bit after every falling serial-clock edge, MSB first
    initial begin
        miso_a = 1'b0;
        miso_b = 1'b0;
        forever begin
            @(negedge csn);
            for (int i = 15; i >= 0; i--) begin
                @(negedge sclk);
                #1;
                miso_a = mdl_a[i];
                miso_b = mdl_b[i];
            end
        end
    end

    always @(posedge clk) if (rst_n && valid) valid_n++;
    always @(negedge csn) begin t_cs_fall = $time; rise_n = 0; fall_seen = 0; end
    always @(posedge csn) t_cs_rise = $time;
    always @(negedge sclk) if (!csn && !fall_seen) begin fall_seen = 1; lead_ns = $time - t_cs_fall; end
    always @(posedge sclk) if (!csn) begin
        if (rise_n > 0) period_ns = $time - t_rise;
        t_rise = $time;
        rise_n++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 5000 && valid !== 1'b1; i++) @(negedge clk);
        chk(valid === 1'b1, "R7 valid strobe seen", 32'(valid), 1);
    endtask

    task automatic frame(input logic [57:0] v);
        mdl_a = v[57:42];
        mdl_b = v[41:26];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(csn === 1'b0, "R2 chip select low after start", 32'(csn), 0);
        chk(busy === 1'b1, "R8 busy after start", 32'(busy), 1);
        wait_valid();
        chk(res_a === v[25:14], "R5 channel A result", 32'(res_a), 32'(v[25:14]));
        chk(res_b === v[13:2], "R5 channel B result", 32'(res_b), 32'(v[13:2]));
        chk(err_a === v[1], "R6 channel A header flag", 32'(err_a), 32'(v[1]));
        chk(err_b === v[0], "R6 channel B header flag", 32'(err_b), 32'(v[0]));
        chk(csn === 1'b1 && busy === 1'b0, "R8 frame closed at valid", {30'd0, csn, busy}, 32'h2);
        chk(rise_n == 16, "R3 rising edges per frame", 32'(rise_n), 16);
        chk(t_cs_rise > t_rise, "R3 chip select rises after last edge", 32'(t_cs_rise), 32'(t_rise));
        chk(lead_ns >= H * CLK_NS, "R2 lead before first fall", 32'(lead_ns), H * CLK_NS);
        chk(period_ns == 2 * H * CLK_NS, "R9 serial clock period", 32'(period_ns), 2 * H * CLK_NS);
        @(negedge clk);
        chk(valid === 1'b0, "R7 valid lasts one cycle", 32'(valid), 0);
        chk(sclk === 1'b1, "R4 clock high while deselected", 32'(sclk), 1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(csn === 1'b1 && sclk === 1'b1, "R1 bus idle in reset", {30'd0, csn, sclk}, 32'h3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && valid === 1'b0, "R1 busy and valid low", {30'd0, busy, valid}, 0);
        chk(csn === 1'b1 && sclk === 1'b1, "R1 bus idle after reset", {30'd0, csn, sclk}, 32'h3);

        for (int k = 0; k < NVEC; k++) frame(VEC[k]);

        // R7: results hold while idle
        repeat (50) @(negedge clk);
        chk(res_a === VEC[NVEC-1][25:14] && res_b === VEC[NVEC-1][13:2],
            "R7 results hold between frames", {8'd0, res_a, res_b}, {8'd0, VEC[NVEC-1][25:2]});

        // R8: start during a frame is ignored
        begin
            int v0;
            v0 = valid_n;
            mdl_a = 16'h0321;
            mdl_b = 16'h9876;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            wait_valid();
            chk(res_a === 12'h321 && err_b === 1'b1, "R8 frame unaffected by second start",
                {19'd0, err_b, res_a}, 32'h1321);
            repeat (3 * 40 * H) @(negedge clk);
            chk(valid_n == v0 + 1, "R8 no extra frame after ignored start", 32'(valid_n - v0), 1);
            chk(csn === 1'b1 && busy === 1'b0, "R8 idle after ignored start", {30'd0, csn, busy}, 32'h2);
        end

        finish_run();
    end
endmodule